// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO with Programmable Thresholds

This block links two clock domains with two independent queues of 18-bit words, one for each direction. Each side has a single port made of an enable and a direction select. On the A side, an enabled clock edge either pushes a word into the A-to-B queue or pops a word from the B-to-A queue. The B side mirrors this arrangement. Pointers cross between the domains as Gray codes through a chain of synchronizer flops. Each side builds its own status from its local pointer and the synchronized far pointer.

For each queue, the writing side owns a full flag and an active-low almost-full flag. The reading side owns an empty flag and an active-low almost-empty flag. Each queue has its own almost-empty threshold (n words) and almost-full threshold (m words). Each threshold is an input that the owning side latches while reset is asserted. A count change caused on the owner's own edge shows on that owner's flag right after that edge. A change caused by the other clock reaches the owner's flags after the synchronizer delay.

Top module: `bififo_top`

## Requirements
- R1: With a_dir=0, an enabled rising clk_a edge pushes a_wdata into the A-to-B queue. With a_dir=1, it pops the B-to-A queue. Port B behaves the same way: b_dir=0 pushes b_wdata into the B-to-A queue, and b_dir=1 pops the A-to-B queue. Edges with the enable low do nothing.
- R2: Words leave each queue in the order they entered. The popped word appears on the popping side's rdata output after the enabled edge that pops it, and rdata holds that word until the next successful pop.
- R3: The empty flag on the reader side is 1 exactly when its queue holds 0 words, once synchronized. The full flag on the writer side is 1 when the queue holds DEPTH words.
- R4: A push into a full queue is dropped, and a pop from an empty queue leaves rdata unchanged. In both cases the queue contents and order stay intact.
- R5: The almost-empty flag (active low) is 0 while the queue holds n or fewer words. It is 1 once the queue holds n+1 or more words.
- R6: The almost-full flag (active low) is 0 while the queue holds DEPTH-m or more words. It is 1 once the count is DEPTH-(m+1) or less.
- R7: A count change made by a side's own enabled edge shows on that side's flags directly after that same edge.
- R8: A count change made by the other clock does not show on a side's flags before two of that side's rising edges. It does show within SYNC_STAGES+1 of them.
- R9: During and right after reset, both queues are empty. empty=1, full=0, almost-empty=0 and almost-full=1 on both sides. The four offset inputs are latched while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst_n | input | 1 | Asynchronous active-low reset; offsets latched while low |
| a_en | input | 1 | Side A operation enable |
| a_dir | input | 1 | Side A select: 0 push A-to-B, 1 pop B-to-A |
| a_wdata | input | WORD_W | Word pushed from side A |
| a_rdata | output | WORD_W | Last word popped by side A |
| a_full | output | 1 | A-to-B queue full |
| a_paf_n | output | 1 | A-to-B almost-full, active low |
| a_empty | output | 1 | B-to-A queue empty |
| a_pae_n | output | 1 | B-to-A almost-empty, active low |
| b_en | input | 1 | Side B operation enable |
| b_dir | input | 1 | Side B select: 0 push B-to-A, 1 pop A-to-B |
| b_wdata | input | WORD_W | Word pushed from side B |
| b_rdata | output | WORD_W | Last word popped by side B |
| b_full | output | 1 | B-to-A queue full |
| b_paf_n | output | 1 | B-to-A almost-full, active low |
| b_empty | output | 1 | A-to-B queue empty |
| b_pae_n | output | 1 | A-to-B almost-empty, active low |
| ab_ae_off | input | OFF_W | Almost-empty threshold n of the A-to-B queue |
| ab_af_off | input | OFF_W | Almost-full threshold m of the A-to-B queue |
| ba_ae_off | input | OFF_W | Almost-empty threshold n of the B-to-A queue |
| ba_af_off | input | OFF_W | Almost-full threshold m of the B-to-A queue |

## Verification
A corrupted pointer shows up as popped words out of order or repeated, on the very pop that reads the bad slot. It also shows as a full or empty flag that disagrees with the bench's word count after the synchronizers settle. A wrong threshold comparison moves the almost-flag edge by one word. The bench catches that on the owner's next edge, since it samples on both sides of each boundary. A synchronizer that is too short makes a far-side flag change after a single owner edge, and the bench samples inside that window.

// File: rtl/bififo_pkg.sv
package bififo_pkg;
   localparam int WORD_W = 18;

   typedef enum logic {
      PORT_PUSH = 1'b0,
      PORT_POP  = 1'b1
   } port_dir_e;
endpackage

// File: rtl/bififo_sync.sv
module bififo_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[k] <= '0;
         else        pipe[k] <= pipe[k-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/bififo_wr_ctl.sv
module bififo_wr_ctl #(
   parameter int AW = 8,
   parameter int PW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic [PW-1:0] off_m,
   input  logic [PW-1:0] rd_gray_s,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [PW-1:0] wr_gray,
   output logic          full,
   output logic          afull_n
);
   localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

   logic [PW-1:0] off_q, wbin, wbin_nx, rbin_s, level;

   always_ff @(posedge clk) begin
      if (!rst_n) off_q <= off_m;
   end

   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rd_gray_s >> i);
   end

   assign level     = wbin - rbin_s;
   assign full      = (level == CAP);
   assign afull_n   = !(level >= CAP - off_q);
   assign mem_we    = push_req && !full;
   assign mem_waddr = wbin[AW-1:0];
   assign wbin_nx   = wbin + PW'(mem_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wr_gray <= '0;
      end else begin
         wbin    <= wbin_nx;
         wr_gray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end
endmodule

// File: rtl/bififo_rd_ctl.sv
module bififo_rd_ctl #(
   parameter int AW = 8,
   parameter int PW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop_req,
   input  logic [PW-1:0] off_n,
   input  logic [PW-1:0] wr_gray_s,
   output logic          mem_re,
   output logic [AW-1:0] mem_raddr,
   output logic [PW-1:0] rd_gray,
   output logic          empty,
   output logic          aempty_n
);
   logic [PW-1:0] off_q, rbin, rbin_nx, wbin_s, level;

   always_ff @(posedge clk) begin
      if (!rst_n) off_q <= off_n;
   end

   always_comb begin
      for (int i = 0; i < PW; i++) wbin_s[i] = ^(wr_gray_s >> i);
   end

   assign level     = wbin_s - rbin;
   assign empty     = (level == '0);
   assign aempty_n  = (level > off_q);
   assign mem_re    = pop_req && !empty;
   assign mem_raddr = rbin[AW-1:0];
   assign rbin_nx   = rbin + PW'(mem_re);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rd_gray <= '0;
      end else begin
         rbin    <= rbin_nx;
         rd_gray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end
endmodule

// File: rtl/bififo_queue.sv
module bififo_queue #(
   parameter int DEPTH  = 256,
   parameter int W      = 18,
   parameter int STAGES = 2,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          rst_n,
   input  logic          wclk,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic [PW-1:0] af_off,
   output logic          full,
   output logic          afull_n,
   input  logic          rclk,
   input  logic          pop,
   input  logic [PW-1:0] ae_off,
   output logic [W-1:0]  rdata,
   output logic          empty,
   output logic          aempty_n
);
   logic [W-1:0]  mem [DEPTH];
   logic          we, re;
   logic [AW-1:0] waddr, raddr;
   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

   bififo_wr_ctl #(.AW(AW), .PW(PW)) u_wr (
      .clk(wclk), .rst_n(rst_n), .push_req(push), .off_m(af_off),
      .rd_gray_s(rgray_s), .mem_we(we), .mem_waddr(waddr),
      .wr_gray(wgray), .full(full), .afull_n(afull_n)
   );

   bififo_rd_ctl #(.AW(AW), .PW(PW)) u_rd (
      .clk(rclk), .rst_n(rst_n), .pop_req(pop), .off_n(ae_off),
      .wr_gray_s(wgray_s), .mem_re(re), .mem_raddr(raddr),
      .rd_gray(rgray), .empty(empty), .aempty_n(aempty_n)
   );

   bififo_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   bififo_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/bififo_top.sv
module bififo_top #(
   parameter int DEPTH       = 256,
   parameter int WORD_W      = bififo_pkg::WORD_W,
   parameter int SYNC_STAGES = 2,
   localparam int OFF_W      = $clog2(DEPTH) + 1
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_dir,
   input  logic [WORD_W-1:0] a_wdata,
   output logic [WORD_W-1:0] a_rdata,
   output logic              a_full,
   output logic              a_paf_n,
   output logic              a_empty,
   output logic              a_pae_n,
   input  logic              b_en,
   input  logic              b_dir,
   input  logic [WORD_W-1:0] b_wdata,
   output logic [WORD_W-1:0] b_rdata,
   output logic              b_full,
   output logic              b_paf_n,
   output logic              b_empty,
   output logic              b_pae_n,
   input  logic [OFF_W-1:0]  ab_ae_off,
   input  logic [OFF_W-1:0]  ab_af_off,
   input  logic [OFF_W-1:0]  ba_ae_off,
   input  logic [OFF_W-1:0]  ba_af_off
);
   import bififo_pkg::*;

   if (DEPTH != 256 && DEPTH != 512) begin : g_bad_depth
      $error("bififo_top: DEPTH must be 256 or 512");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bififo_top: SYNC_STAGES must be at least 2");
   end

   logic a_push, a_pop, b_push, b_pop;
   assign a_push = a_en && (port_dir_e'(a_dir) == PORT_PUSH);
   assign a_pop  = a_en && (port_dir_e'(a_dir) == PORT_POP);
   assign b_push = b_en && (port_dir_e'(b_dir) == PORT_PUSH);
   assign b_pop  = b_en && (port_dir_e'(b_dir) == PORT_POP);

   bififo_queue #(.DEPTH(DEPTH), .W(WORD_W), .STAGES(SYNC_STAGES)) u_ab (
      .rst_n(rst_n),
      .wclk(clk_a), .push(a_push), .wdata(a_wdata), .af_off(ab_af_off),
      .full(a_full), .afull_n(a_paf_n),
      .rclk(clk_b), .pop(b_pop), .ae_off(ab_ae_off),
      .rdata(b_rdata), .empty(b_empty), .aempty_n(b_pae_n)
   );

   bififo_queue #(.DEPTH(DEPTH), .W(WORD_W), .STAGES(SYNC_STAGES)) u_ba (
      .rst_n(rst_n),
      .wclk(clk_b), .push(b_push), .wdata(b_wdata), .af_off(ba_af_off),
      .full(b_full), .afull_n(b_paf_n),
      .rclk(clk_a), .pop(a_pop), .ae_off(ba_ae_off),
      .rdata(a_rdata), .empty(a_empty), .aempty_n(a_pae_n)
   );
endmodule

// File: rtl/bififo_checker.sv
module bififo_checker #(
   parameter int WORD_W = 18
) (
   input logic              clk_a,
   input logic              clk_b,
   input logic              rst_n,
   input logic              a_en,
   input logic              a_dir,
   input logic [WORD_W-1:0] a_rdata,
   input logic              a_full,
   input logic              a_paf_n,
   input logic              a_empty,
   input logic              a_pae_n,
   input logic              b_en,
   input logic              b_dir,
   input logic [WORD_W-1:0] b_rdata,
   input logic              b_full,
   input logic              b_paf_n,
   input logic              b_empty,
   input logic              b_pae_n
);
   AST_A_FULL_IN_PAF: assert property (@(posedge clk_a) disable iff (!rst_n)
      a_full |-> !a_paf_n); // R6
   AST_B_FULL_IN_PAF: assert property (@(posedge clk_b) disable iff (!rst_n)
      b_full |-> !b_paf_n); // R6
   AST_A_EMPTY_IN_PAE: assert property (@(posedge clk_a) disable iff (!rst_n)
      a_empty |-> !a_pae_n); // R5
   AST_B_EMPTY_IN_PAE: assert property (@(posedge clk_b) disable iff (!rst_n)
      b_empty |-> !b_pae_n); // R5
   AST_A_FULL_RISE_OWN: assert property (@(posedge clk_a) disable iff (!rst_n)
      $rose(a_full) |-> $past(a_en && !a_dir)); // R7
   AST_B_EMPTY_RISE_OWN: assert property (@(posedge clk_b) disable iff (!rst_n)
      $rose(b_empty) |-> $past(b_en && b_dir)); // R7
   AST_A_EMPTY_POP_HOLD: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_en && a_dir && a_empty) |=> $stable(a_rdata)); // R4
   AST_B_EMPTY_POP_HOLD: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_en && b_dir && b_empty) |=> $stable(b_rdata)); // R4
endmodule

bind bififo_top bififo_checker #(.WORD_W(WORD_W)) u_chk (
   .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
   .a_en(a_en), .a_dir(a_dir), .a_rdata(a_rdata), .a_full(a_full),
   .a_paf_n(a_paf_n), .a_empty(a_empty), .a_pae_n(a_pae_n),
   .b_en(b_en), .b_dir(b_dir), .b_rdata(b_rdata), .b_full(b_full),
   .b_paf_n(b_paf_n), .b_empty(b_empty), .b_pae_n(b_pae_n)
);

// File: tb/tb_bififo_top.sv
module tb_bififo_top;
   localparam int CLK_A_PERIOD = 10;
   localparam int CLK_B_PERIOD = 14;
   localparam int DEPTH = 256;
   localparam int OFF_W = $clog2(DEPTH) + 1;

   logic clk_a = 0, clk_b = 0, rst_n = 1;
   logic a_en = 0, a_dir = 0, b_en = 0, b_dir = 0;
   logic [17:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
   logic a_full, a_paf_n, a_empty, a_pae_n, b_full, b_paf_n, b_empty, b_pae_n;
   logic [OFF_W-1:0] ab_ae_off = 3, ab_af_off = 4, ba_ae_off = 7, ba_af_off = 7;

   int n_tests = 0, n_fail = 0;

   bififo_top #(.DEPTH(DEPTH)) dut (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
      .a_en(a_en), .a_dir(a_dir), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .a_full(a_full), .a_paf_n(a_paf_n), .a_empty(a_empty), .a_pae_n(a_pae_n),
      .b_en(b_en), .b_dir(b_dir), .b_wdata(b_wdata), .b_rdata(b_rdata),
      .b_full(b_full), .b_paf_n(b_paf_n), .b_empty(b_empty), .b_pae_n(b_pae_n),
      .ab_ae_off(ab_ae_off), .ab_af_off(ab_af_off),
      .ba_ae_off(ba_ae_off), .ba_af_off(ba_af_off)
   );

   always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
   always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

   typedef struct packed {
      logic        on_b;
      logic        pop;
      logic [17:0] val;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b0, 18'h00011}, '{1'b0, 1'b0, 18'h3ABCD},
      '{1'b0, 1'b0, 18'h00F0F}, '{1'b1, 1'b0, 18'h12345},
      '{1'b1, 1'b1, 18'h00011}, '{1'b1, 1'b1, 18'h3ABCD},
      '{1'b1, 1'b1, 18'h00F0F}, '{1'b0, 1'b1, 18'h12345}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic a_op(input logic dir, input logic [17:0] d);
      @(negedge clk_a); a_en = 1; a_dir = dir; a_wdata = d;
      @(negedge clk_a); a_en = 0;
   endtask

   task automatic b_op(input logic dir, input logic [17:0] d);
      @(negedge clk_b); b_en = 1; b_dir = dir; b_wdata = d;
      @(negedge clk_b); b_en = 0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk_b);
      repeat (4) @(negedge clk_a);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_A_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      finish_run();
   end

   initial begin
      #2 rst_n = 0;
      repeat (5) @(negedge clk_b);
      rst_n = 1;
      repeat (2) @(negedge clk_a);
      // R9 reset state
      check("R9 a_empty", a_empty, 1);  check("R9 b_empty", b_empty, 1);
      check("R9 a_full", a_full, 0);    check("R9 b_full", b_full, 0);
      check("R9 a_pae_n", a_pae_n, 0);  check("R9 b_pae_n", b_pae_n, 0);
      check("R9 a_paf_n", a_paf_n, 1);  check("R9 b_paf_n", b_paf_n, 1);

      // R1 R2 table: direction select and ordering in both queues
      foreach (VEC[i]) begin
         if (VEC[i].pop) settle();
         if (VEC[i].on_b) b_op(VEC[i].pop, VEC[i].val);
         else             a_op(VEC[i].pop, VEC[i].val);
         if (VEC[i].pop) begin
            if (VEC[i].on_b) check("R1 R2 b_rdata", b_rdata, VEC[i].val);
            else             check("R1 R2 a_rdata", a_rdata, VEC[i].val);
         end
      end
      settle();
      check("R3 a_empty after drain", a_empty, 1);
      check("R3 b_empty after drain", b_empty, 1);

      // R4 pop from empty ignored, pointers intact
      a_op(1'b1, '0);
      check("R4 a_rdata held", a_rdata, 18'h12345);
      check("R4 a_empty held", a_empty, 1);
      b_op(1'b0, 18'h2468A);
      settle();
      check("R3 a_empty cleared", a_empty, 0);
      a_op(1'b1, '0);
      check("R4 a_rdata next word", a_rdata, 18'h2468A);

      // R5 R7 R8 almost-empty on A-to-B with n=3
      for (int i = 0; i < 3; i++) a_op(1'b0, 18'(32'h100 + i));
      settle();
      check("R5 b_pae_n at n", b_pae_n, 0);
      a_op(1'b0, 18'h103);
      check("R8 b_pae_n not yet", b_pae_n, 0);
      settle();
      check("R5 R8 b_pae_n at n+1", b_pae_n, 1);
      b_op(1'b1, '0);
      check("R7 b_pae_n own pop", b_pae_n, 0);
      check("R2 b_rdata", b_rdata, 18'h100);
      for (int i = 1; i < 4; i++) begin
         b_op(1'b1, '0);
         check("R2 b_rdata", b_rdata, 18'(32'h100 + i));
      end
      check("R7 b_empty own pop", b_empty, 1);

      // R3 R6 R7 almost-full and full on A-to-B with m=4
      settle();
      for (int i = 0; i < DEPTH; i++) begin
         a_op(1'b0, 18'(32'h200 + i));
         if (i == DEPTH - 6) check("R6 a_paf_n at DEPTH-5", a_paf_n, 1);
         if (i == DEPTH - 5) check("R6 R7 a_paf_n at DEPTH-4", a_paf_n, 0);
         if (i == DEPTH - 2) check("R3 a_full below DEPTH", a_full, 0);
      end
      check("R3 a_full at DEPTH", a_full, 1);
      a_op(1'b0, 18'h3FFFF);
      check("R4 a_full after dropped push", a_full, 1);
      settle();
      for (int i = 0; i < 4; i++) b_op(1'b1, '0);
      settle();
      check("R6 a_paf_n at DEPTH-4", a_paf_n, 0);
      check("R3 a_full cleared", a_full, 0);
      b_op(1'b1, '0);
      settle();
      check("R6 a_paf_n at DEPTH-5", a_paf_n, 1);
      check("R2 b_rdata 5th", b_rdata, 18'h204);
      for (int i = 5; i < DEPTH; i++) begin
         b_op(1'b1, '0);
         check("R2 R4 full drain order", b_rdata, 18'(32'h200 + i));
      end
      check("R3 b_empty after full drain", b_empty, 1);
      b_op(1'b1, '0);
      check("R4 dropped word absent", b_rdata, 18'(32'h200 + DEPTH - 1));
      finish_run();
   end
endmodule